// File: doc/BRIEF.md
# Transport stream sync tracker

The block sits behind a byte-wide transport stream input and works out where each packet begins. Each accepted byte comes with a valid strobe and may carry a start hint from the source. While unlocked, the tracker scans the stream one byte at a time for a programmable sync token. A candidate start counts only if the token shows up again exactly one packet length later. After a programmable number of consecutive confirmed tokens, the tracker declares lock.

Once locked, the tracker looks for the token only where the next packet should start. It passes every byte downstream one cycle later, tagged with its index in the packet and with start and end pulses. A run of wrong bytes at the expected start positions, as long as a second programmable count, drops the lock. The byte at which lock is lost leaves the block marked as errored, so the receiver can discard the packet it was assembling. Packets are byte aligned with the first byte transmitted first. Recommended settings are kept in the package: token 0x47, 188-byte packets, and 9 for both counts.

Top module: `ts_sync_tracker`

## Requirements
- R1: A synchronous reset clears lock and all counters. In the cycle after reset, `locked` and `out_valid` are low. Lock after reset needs the full count of fresh tokens, even when reset arrives while locked.
- R2: While hunting, a token byte is only a candidate. It becomes a confirmed start only if the byte exactly `cfg_len` valid bytes later equals the token. If that byte is not the token, hunting resumes with the next byte. A lone token byte whose follow-up check fails therefore delays lock.
- R3: `locked` rises in the cycle after the input byte carrying the `cfg_lock_cnt`-th consecutive correct token (a count of 0 acts as 1). That byte leaves the block in the same cycle with `out_sop` high and index 0.
- R4: While locked, every valid input byte appears on `out_data` one cycle later with `out_valid` high. `out_idx` counts from 0 to `cfg_len`-1 and then wraps. `out_sop` is high at index 0 and `out_eop` is high at index `cfg_len`-1.
- R5: No byte is emitted while unlocked. The only exception is the byte that ends lock (R7).
- R6: While locked, the token is compared only at index 0. A wrong byte there adds one miss, and that packet is still emitted with `out_sop` high. A correct token clears the miss count.
- R7: Lock is lost at the `cfg_drop_cnt`-th consecutive miss (a count of 0 acts as 1). In the following cycle, `locked` is low and that byte is emitted with `out_err` and `out_eop` high, `out_sop` low and index 0.
- R8: A cycle with `in_valid` low emits nothing and advances no counter or position.
- R9: The token, the packet length (at least 5) and both counts are taken from the configuration inputs.
- R10: With the parameter HINT_GATE set to 1, the hunt accepts a token byte as a candidate only when `in_sop` is high. With the default of 0, the hint plays no part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input stream byte |
| in_sop | input | 1 | Start hint from the source |
| cfg_token | input | 8 | Sync token value |
| cfg_len | input | LEN_W | Packet length in bytes |
| cfg_lock_cnt | input | CNT_W | Consecutive good tokens needed for lock |
| cfg_drop_cnt | input | CNT_W | Consecutive misses that end lock |
| locked | output | 1 | Tracker is locked |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet, or the loss byte |
| out_err | output | 1 | Lock lost on this byte |
| out_idx | output | LEN_W | Byte index within the packet |

## Verification
The hardest state to reach is a hunt that is misled by a stray token. A lone token is placed three bytes before the real stream, so its check lands inside the first packet's payload. This proves that the failed candidate is discarded and that lock arrives one packet later. The second hard case is a miss count cleared by a good token. The stimulus inserts one bad start, then one good start, then a bad run, so the loss falls exactly `cfg_drop_cnt` packets into the final run. These scenarios are swept over every lock and drop count from 0 to 4 and 0 to 3, two tokens and two lengths, with idle cycles mixed in.

// File: rtl/ts_sync_pkg.sv
package ts_sync_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCK   = 2'd2
    } trk_state_e;

    localparam logic [7:0] TS_TOKEN_DEFAULT = 8'h47;
    localparam int         TS_LEN_DEFAULT   = 188;
    localparam int         TS_LOCK_DEFAULT  = 9;
    localparam int         TS_DROP_DEFAULT  = 9;
endpackage

// File: rtl/ts_sync_detect.sv
module ts_sync_detect #(
    parameter int DATA_W    = 8,
    parameter int HINT_GATE = 0
) (
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic [DATA_W-1:0] cfg_token,
    output logic              is_token,
    output logic              may_start
);
    localparam logic GATE = (HINT_GATE != 0);

    assign is_token  = (in_data == cfg_token);
    // hunt candidate: token, and the hint too when gating is chosen
    assign may_start = is_token & (in_sop | ~GATE);
endmodule

// File: rtl/ts_sync_reach.sv
module ts_sync_reach #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] thr,
    output logic             hit
);
    // true when one more event reaches the threshold (0 behaves as 1)
    assign hit = ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, thr};
endmodule

// File: rtl/ts_sync_fsm.sv
module ts_sync_fsm
    import ts_sync_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              is_token,
    input  logic              may_start,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              lock_hit,
    input  logic              drop_hit,
    output logic [CNT_W-1:0]  cnt,
    output logic              locked,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_err,
    output logic [LEN_W-1:0]  out_idx
);
    typedef struct packed {
        trk_state_e        st;
        logic [LEN_W-1:0]  pos;
        logic [CNT_W-1:0]  cnt;
        logic              o_valid;
        logic              o_sop;
        logic              o_eop;
        logic              o_err;
        logic [DATA_W-1:0] o_data;
        logic [LEN_W-1:0]  o_idx;
    } trk_t;

    trk_t trk_d, trk_q;

    logic [LEN_W-1:0] last_pos;
    logic             at_start;
    logic             lose;

    assign last_pos = cfg_len - LEN_W'(1);
    assign at_start = (trk_q.pos == '0);
    assign lose     = at_start && !is_token && drop_hit;

    always_comb begin
        trk_d         = trk_q;
        trk_d.o_valid = 1'b0;
        trk_d.o_sop   = 1'b0;
        trk_d.o_eop   = 1'b0;
        trk_d.o_err   = 1'b0;
        if (in_valid) begin
            unique case (trk_q.st)
                ST_HUNT: begin
                    if (may_start) begin
                        trk_d.pos = LEN_W'(1);
                        if (lock_hit) begin
                            trk_d.st      = ST_LOCK;
                            trk_d.cnt     = '0;
                            trk_d.o_valid = 1'b1;
                            trk_d.o_sop   = 1'b1;
                            trk_d.o_data  = in_data;
                            trk_d.o_idx   = '0;
                        end else begin
                            trk_d.st  = ST_VERIFY;
                            trk_d.cnt = CNT_W'(1);
                        end
                    end
                end
                ST_VERIFY: begin
                    if (trk_q.pos == cfg_len) begin
                        if (is_token) begin
                            trk_d.pos = LEN_W'(1);
                            if (lock_hit) begin
                                trk_d.st      = ST_LOCK;
                                trk_d.cnt     = '0;
                                trk_d.o_valid = 1'b1;
                                trk_d.o_sop   = 1'b1;
                                trk_d.o_data  = in_data;
                                trk_d.o_idx   = '0;
                            end else begin
                                trk_d.cnt = trk_q.cnt + CNT_W'(1);
                            end
                        end else begin
                            trk_d.st  = ST_HUNT;
                            trk_d.pos = '0;
                            trk_d.cnt = '0;
                        end
                    end else begin
                        trk_d.pos = trk_q.pos + LEN_W'(1);
                    end
                end
                ST_LOCK: begin
                    trk_d.o_valid = 1'b1;
                    trk_d.o_data  = in_data;
                    if (lose) begin
                        trk_d.st    = ST_HUNT;
                        trk_d.pos   = '0;
                        trk_d.cnt   = '0;
                        trk_d.o_err = 1'b1;
                        trk_d.o_eop = 1'b1;
                        trk_d.o_idx = '0;
                    end else begin
                        if (at_start) begin
                            trk_d.cnt = is_token ? '0 : trk_q.cnt + CNT_W'(1);
                        end
                        trk_d.o_idx = trk_q.pos;
                        trk_d.o_sop = at_start;
                        trk_d.o_eop = (trk_q.pos == last_pos);
                        trk_d.pos   = (trk_q.pos == last_pos) ? '0
                                                              : trk_q.pos + LEN_W'(1);
                    end
                end
                default: trk_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign cnt       = trk_q.cnt;
    assign locked    = (trk_q.st == ST_LOCK);
    assign out_valid = trk_q.o_valid;
    assign out_data  = trk_q.o_data;
    assign out_sop   = trk_q.o_sop;
    assign out_eop   = trk_q.o_eop;
    assign out_err   = trk_q.o_err;
    assign out_idx   = trk_q.o_idx;
endmodule

// File: rtl/ts_sync_tracker.sv
module ts_sync_tracker #(
    parameter int LEN_W     = 8,
    parameter int CNT_W     = 4,
    parameter int HINT_GATE = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sop,
    input  logic [7:0]       cfg_token,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [CNT_W-1:0] cfg_lock_cnt,
    input  logic [CNT_W-1:0] cfg_drop_cnt,
    output logic             locked,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sop,
    output logic             out_eop,
    output logic             out_err,
    output logic [LEN_W-1:0] out_idx
);
    localparam int DATA_W = 8;

    logic             is_token;
    logic             may_start;
    logic             lock_hit;
    logic             drop_hit;
    logic [CNT_W-1:0] cnt;

    ts_sync_detect #(.DATA_W(DATA_W), .HINT_GATE(HINT_GATE)) u_detect (
        .in_data   (in_data),
        .in_sop    (in_sop),
        .cfg_token (cfg_token),
        .is_token  (is_token),
        .may_start (may_start)
    );

    ts_sync_reach #(.CNT_W(CNT_W)) u_lock_reach (
        .cnt (cnt),
        .thr (cfg_lock_cnt),
        .hit (lock_hit)
    );

    ts_sync_reach #(.CNT_W(CNT_W)) u_drop_reach (
        .cnt (cnt),
        .thr (cfg_drop_cnt),
        .hit (drop_hit)
    );

    ts_sync_fsm #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .is_token  (is_token),
        .may_start (may_start),
        .cfg_len   (cfg_len),
        .lock_hit  (lock_hit),
        .drop_hit  (drop_hit),
        .cnt       (cnt),
        .locked    (locked),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_err   (out_err),
        .out_idx   (out_idx)
    );
endmodule

// File: rtl/ts_sync_tracker_chk.sv
module ts_sync_tracker_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [LEN_W-1:0] cfg_len,
    input logic             locked,
    input logic             out_valid,
    input logic             out_sop,
    input logic             out_eop,
    input logic             out_err,
    input logic [LEN_W-1:0] out_idx
);
    AST_UNLOCKED_ONLY_ERR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !locked) |-> out_err); // R5

    AST_SOP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop) |-> (out_idx == '0)); // R4

    AST_EOP_AT_LAST: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_eop && !out_err) |-> (out_idx == cfg_len - LEN_W'(1))); // R4

    AST_LOCK_STARTS_PKT: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (out_valid && out_sop)); // R3

    AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> !out_valid); // R8

    AST_ERR_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err) |-> (!locked && out_eop && !out_sop)); // R7

    AST_LOSS_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        ($fell(locked) && !$past(rst)) |-> (out_valid && out_err)); // R7
endmodule

bind ts_sync_tracker ts_sync_tracker_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .cfg_len   (cfg_len),
    .locked    (locked),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_err   (out_err),
    .out_idx   (out_idx)
);

// File: tb/ts_sync_tracker_test.sv
`timescale 1ns/1ps
module ts_sync_tracker_test;
    import ts_sync_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_sop = 1'b0;
    logic [7:0] cfg_token = 8'h47;
    logic [7:0] cfg_len = 8'd5;
    logic [3:0] cfg_lock_cnt = 4'd2;
    logic [3:0] cfg_drop_cnt = 4'd2;

    logic       locked, out_valid, out_sop, out_eop, out_err;
    logic [7:0] out_data, out_idx;
    logic       g_locked, g_valid, g_sop, g_eop, g_err;
    logic [7:0] g_data, g_idx;

    int checks = 0;
    int errors = 0;
    int gc = 0;

    always #4 clk = ~clk;

    ts_sync_tracker uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop),
        .cfg_token(cfg_token), .cfg_len(cfg_len), .cfg_lock_cnt(cfg_lock_cnt),
        .cfg_drop_cnt(cfg_drop_cnt), .locked(locked), .out_valid(out_valid),
        .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err),
        .out_idx(out_idx)
    );

    ts_sync_tracker #(.HINT_GATE(1)) uut_gate (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop),
        .cfg_token(cfg_token), .cfg_len(cfg_len), .cfg_lock_cnt(cfg_lock_cnt),
        .cfg_drop_cnt(cfg_drop_cnt), .locked(g_locked), .out_valid(g_valid),
        .out_data(g_data), .out_sop(g_sop), .out_eop(g_eop), .out_err(g_err),
        .out_idx(g_idx)
    );

    task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic v, input logic [7:0] d, input logic s);
        in_valid = v;
        in_data  = d;
        in_sop   = s;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [20:0] act_vec(input logic full);
        if (full)
            return {out_valid, out_sop, out_eop, out_err, locked, out_idx, out_data};
        return {out_valid, 3'b000, locked, 16'h0000};
    endfunction

    task automatic step(input logic [7:0] d, input logic s, input logic ev, input logic es,
                        input logic ee, input logic er, input logic el, input logic [7:0] ei,
                        input string tag);
        logic [20:0] exp;
        tick(1'b1, d, s);
        if (ev) exp = {1'b1, es, ee, er, el, ei, d};
        else    exp = {1'b0, 3'b000, el, 16'h0000};
        check(tag, act_vec(ev), exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(1'b0, 8'h00, 1'b0);
        check("R1 reset state", act_vec(1'b0), 21'h0);
        rst = 1'b0;
    endtask

    function automatic logic [7:0] pay(input int p, input int i, input logic [7:0] tok);
        logic [7:0] v;
        v = 8'(p * 3 + i * 7 + 1);
        if (v == tok) v = v + 8'd1;
        return v;
    endfunction

    task automatic run(input int lk, input int dr, input int ln, input logic [7:0] tok,
                       input logic fake_in);
        int  elk, edr, g, total, lockp, lossp;
        logic fake, el;
        elk  = (lk == 0) ? 1 : lk;
        edr  = (dr == 0) ? 1 : dr;
        fake = fake_in && (elk >= 2);
        cfg_token    = tok;
        cfg_len      = 8'(ln);
        cfg_lock_cnt = 4'(lk);
        cfg_drop_cnt = 4'(dr);
        do_reset();
        g     = elk + 3;
        total = g + 2 + edr + 1;
        lockp = fake ? elk : elk - 1;
        lossp = (edr == 1) ? g : g + 2 + edr - 1;
        el = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step((fake && k == 0) ? tok : (tok ^ 8'h55), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                 1'b0, 8'h00, "R2 prefix");
        end
        for (int p = 0; p < total; p++) begin
            for (int i = 0; i < ln; i++) begin
                logic good, ev, es, ee, er;
                logic [7:0] d, ei;
                string tag;
                good = (p < g) || (p == g + 1 && edr >= 2);
                d = (i == 0) ? (good ? tok : (tok ^ 8'hFF)) : pay(p, i, tok);
                if (p >= lockp && p < lossp) begin
                    ev = 1; es = (i == 0); ee = (i == ln - 1); er = 0; el = 1; ei = 8'(i);
                end else if (p == lossp && i == 0) begin
                    ev = 1; es = 0; ee = 1; er = 1; el = 0; ei = 8'h00;
                end else begin
                    ev = 0; es = 0; ee = 0; er = 0; el = 0; ei = 8'h00;
                end
                if (er) tag = "R7 loss byte";
                else if (ev && p == lockp && i == 0) tag = "R3 lock entry";
                else if (ev && p == g && i == 0) tag = "R6 tolerated miss";
                else if (ev && p == g + 1 && i == 0) tag = "R6 miss cleared";
                else if (ev) tag = "R4 emitted byte";
                else if (fake && p <= lockp) tag = "R2 unconfirmed";
                else tag = "R5 silent while unlocked";
                step(d, (i == 0) && good, ev, es, ee, er, el, ei, tag);
                gc++;
                if (gc % 5 == 3) begin
                    tick(1'b0, 8'hA5, 1'b0);
                    check("R8 idle cycle", act_vec(1'b0), {1'b0, 3'b000, el, 16'h0000});
                end
            end
        end
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R9 sweep of configuration values
        for (int lk = 0; lk <= 4; lk++)
            for (int dr = 0; dr <= 3; dr++)
                for (int li = 0; li < 2; li++)
                    for (int ti = 0; ti < 2; ti++)
                        for (int f = 0; f < 2; f++)
                            run(lk, dr, (li == 0) ? 5 : 12, (ti == 0) ? 8'h47 : 8'hB8, f[0]);
        // R9 recommended settings
        run(TS_LOCK_DEFAULT, TS_DROP_DEFAULT, TS_LEN_DEFAULT, TS_TOKEN_DEFAULT, 1'b1);

        // R10 hint gating: no hint, gated copy must stay unlocked
        cfg_token = 8'h47; cfg_len = 8'd5; cfg_lock_cnt = 4'd2; cfg_drop_cnt = 4'd2;
        do_reset();
        for (int p = 0; p < 3; p++)
            for (int i = 0; i < 5; i++)
                tick(1'b1, (i == 0) ? 8'h47 : pay(p, i, 8'h47), 1'b0);
        check("R10 gated without hint", {20'h0, g_locked}, 21'h0);
        check("R10 ungated locks", {20'h0, locked}, 21'h1);
        for (int p = 3; p < 5; p++)
            for (int i = 0; i < 5; i++) begin
                tick(1'b1, (i == 0) ? 8'h47 : pay(p, i, 8'h47), i == 0);
                if (p == 4 && i == 0)
                    check("R10 gated with hint", {19'h0, g_locked, g_sop}, 21'h3);
            end

        // R1 reset while locked, in mid packet
        tick(1'b1, 8'h47, 1'b1);
        tick(1'b1, pay(5, 1, 8'h47), 1'b0);
        rst = 1'b1;
        tick(1'b0, 8'h00, 1'b0);
        check("R1 reset while locked", act_vec(1'b0), 21'h0);
        rst = 1'b0;
        for (int i = 2; i < 5; i++) tick(1'b1, pay(5, i, 8'h47), 1'b0);
        tick(1'b1, 8'h47, 1'b1);
        check("R1 counters cleared", act_vec(1'b0), 21'h0);
        for (int i = 1; i < 5; i++) tick(1'b1, pay(6, i, 8'h47), 1'b0);
        tick(1'b1, 8'h47, 1'b1);
        check("R1 relock after full count", act_vec(1'b1),
              {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h47});
        tick(1'b0, 8'h00, 1'b0);
        finish_up();
    end
endmodule